// File: doc/BRIEF.md
# Deterministic-Latency Receive Phase Aligner

This controller gives a serial receive path the same latency after every reset. A transceiver's recovered clock can lock onto any one of the ten bit positions of a 10-bit symbol, so the phase of the parallel clock changes from one reset to the next. The controller works against a reference receiver that is never reset. It keeps pulsing the reset of the receiver under alignment until the measured phase lands where it is wanted. Comma alignment is done in logic afterwards and must leave this clock phase alone. The elastic and transmit buffers are assumed to be bypassed, so the phase this block settles on is the only thing that sets the latency.

A start request first runs the transmit side. The controller pulses the transmit reset until the transmit phase code equals the target. The receive side then uses two stages. In stage one, receiver resets repeat until the phase difference to the reference reaches its largest value. In stage two, they repeat until the difference equals the fixed earliest target phase. After each reset is released, the controller waits a programmable settle time before it accepts a measurement. Each stage is bounded by a retry limit. The controller ends in a locked state with a done flag, or in a failed state with an error flag.

Top module: `lat_align_ctrl`

## Requirements
- R1: After reset, every output is low. A start request sampled while the controller is not busy raises `tx_rst_o` on the next cycle.
- R2: Every transmit or receive reset pulse lasts exactly `rst_len_i` cycles. A value of 0 is treated as 1.
- R3: Transmit resets repeat until a transmit measurement equals TARGET_PHASE (default 0). No receive reset is issued before that measurement is accepted.
- R4: Measurements that arrive in the first S cycles after a reset is released are ignored, where S is `settle_len_i` with 0 treated as 1. A measurement in cycle S is acted on, so each attempt takes L+S+1 cycles, where L is the effective pulse length.
- R5: In stage one, receive resets repeat until the code equals NUM_PHASES-1 (default 9). Codes of NUM_PHASES or more count as mismatches.
- R6: In stage two, receive resets repeat until the code equals TARGET_PHASE. `done_o` rises on the clock edge that accepts the matching measurement.
- R7: Each stage issues at most MAX_TRIES resets. A mismatch after the last of them raises `err_o` and drops `busy_o` on the edge that accepts that measurement. `err_o` then stays high.
- R8: `done_o` holds until `start_i` or `lol_i` is sampled high. `lol_i` returns the controller to idle with all flags low.
- R9: A start request while locked or failed restarts from the transmit stage and clears `err_o`. A start request while busy has no effect on the sequence or its timing.
- R10: `busy_o`, `done_o` and `err_o` are never high together, and `tx_rst_o` and `rx_rst_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start or restart request |
| lol_i | input | 1 | Loss of lock; leaves the locked state |
| rst_len_i | input | CNT_W | Reset pulse length in cycles |
| settle_len_i | input | CNT_W | Cycles of ignored measurements after each release |
| tx_phase_i | input | PHASE_W | Transmit phase code |
| tx_phase_vld_i | input | 1 | One-cycle strobe for tx_phase_i |
| rx_phase_i | input | PHASE_W | Receive phase difference to the reference |
| rx_phase_vld_i | input | 1 | One-cycle strobe for rx_phase_i |
| tx_rst_o | output | 1 | Transmitter reset pulse |
| rx_rst_o | output | 1 | Reset pulse for the receiver under alignment |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Locked |
| err_o | output | 1 | Retry limit exceeded |

## Verification
Take the edge that samples start as e0, and let T = L+S+1. `done_o` is due exactly (ntx+nrx)·T edges after e0, where ntx and nrx are the numbers of transmit and receive attempts. In a failing stage, `err_o` is due after the same count of attempts. The bench computes these edge counts and samples one cycle before the due edge, expecting the old value, and just after it, expecting the new one. A responder in the bench answers each reset release at cycle S, and can also place a matching decoy code at cycle S-1. It measures every reset pulse and counts pulses per side, so both the widths and the totals are checked against these formulas.

// File: rtl/lat_align_pkg.sv
package lat_align_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_TX_RESET,
    ST_TX_WAIT,
    ST_RX_RESET,
    ST_RX_SETTLE,
    ST_MEASURE_MAX,
    ST_MEASURE_TARGET,
    ST_LOCKED,
    ST_FAIL
  } align_state_e;
endpackage

// File: rtl/la_cycle_timer.sv
module la_cycle_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/la_retry_cnt.sv
module la_retry_cnt #(
  parameter int unsigned MAX_TRIES = 255
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic spent_o
);
  localparam int unsigned TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [TRY_W-1:0] LIMIT = TRY_W'(MAX_TRIES);

  logic [TRY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= inc_i ? TRY_W'(1) : '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign spent_o = (cnt_q >= LIMIT);
endmodule

// File: rtl/la_code_eq.sv
module la_code_eq #(
  parameter int unsigned PHASE_W = 4,
  parameter int unsigned REF     = 0
) (
  input  logic [PHASE_W-1:0] code_i,
  output logic               hit_o
);
  localparam logic [PHASE_W-1:0] REF_CODE = PHASE_W'(REF);
  assign hit_o = (code_i == REF_CODE);
endmodule

// File: rtl/lat_align_ctrl.sv
module lat_align_ctrl
  import lat_align_pkg::*;
#(
  parameter int unsigned PHASE_W      = 4,
  parameter int unsigned NUM_PHASES   = 10,
  parameter int unsigned TARGET_PHASE = 0,
  parameter int unsigned CNT_W        = 8,
  parameter int unsigned MAX_TRIES    = 255
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               lol_i,
  input  logic [CNT_W-1:0]   rst_len_i,
  input  logic [CNT_W-1:0]   settle_len_i,
  input  logic [PHASE_W-1:0] tx_phase_i,
  input  logic               tx_phase_vld_i,
  input  logic [PHASE_W-1:0] rx_phase_i,
  input  logic               rx_phase_vld_i,
  output logic               tx_rst_o,
  output logic               rx_rst_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o
);
  localparam int unsigned MAX_DIFF = NUM_PHASES - 1;
  localparam int unsigned EW       = CNT_W + 1;

  align_state_e     state_q, state_d;
  logic             stage2_q, stage2_d;
  logic [CNT_W-1:0] tmr_cnt;
  logic             tmr_clr;
  logic [EW-1:0]    cnt_nx, rst_eff, settle_eff;
  logic             rst_last, settle_last, settled;
  logic             tx_hit, rx_max_hit, rx_tgt_hit;
  logic             try_clr, try_inc, try_spent;

  la_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tmr_clr),
    .cnt_o (tmr_cnt)
  );

  la_retry_cnt #(.MAX_TRIES(MAX_TRIES)) u_retry (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (try_clr),
    .inc_i  (try_inc),
    .spent_o(try_spent)
  );

  la_code_eq #(.PHASE_W(PHASE_W), .REF(TARGET_PHASE)) u_tx_tgt (
    .code_i(tx_phase_i), .hit_o(tx_hit)
  );
  la_code_eq #(.PHASE_W(PHASE_W), .REF(MAX_DIFF)) u_rx_max (
    .code_i(rx_phase_i), .hit_o(rx_max_hit)
  );
  la_code_eq #(.PHASE_W(PHASE_W), .REF(TARGET_PHASE)) u_rx_tgt (
    .code_i(rx_phase_i), .hit_o(rx_tgt_hit)
  );

  // zero lengths behave as one cycle
  assign rst_eff     = (rst_len_i == '0)    ? EW'(1) : {1'b0, rst_len_i};
  assign settle_eff  = (settle_len_i == '0) ? EW'(1) : {1'b0, settle_len_i};
  assign cnt_nx      = {1'b0, tmr_cnt} + EW'(1);
  assign rst_last    = (cnt_nx >= rst_eff);
  assign settle_last = (cnt_nx >= settle_eff);
  assign settled     = ({1'b0, tmr_cnt} >= settle_eff);

  always_comb begin
    state_d  = state_q;
    stage2_d = stage2_q;
    try_clr  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_LOCKED, ST_FAIL: begin
        if (start_i) begin
          state_d  = ST_TX_RESET;
          stage2_d = 1'b0;
          try_clr  = 1'b1;
        end else if (state_q == ST_LOCKED && lol_i) begin
          state_d = ST_IDLE;
        end
      end
      ST_TX_RESET: if (rst_last) state_d = ST_TX_WAIT;
      ST_TX_WAIT: begin
        if (settled && tx_phase_vld_i) begin
          if (tx_hit) begin
            state_d = ST_RX_RESET;
            try_clr = 1'b1;
          end else if (try_spent) begin
            state_d = ST_FAIL;
          end else begin
            state_d = ST_TX_RESET;
          end
        end
      end
      ST_RX_RESET: if (rst_last) state_d = ST_RX_SETTLE;
      ST_RX_SETTLE: begin
        if (settle_last) state_d = stage2_q ? ST_MEASURE_TARGET : ST_MEASURE_MAX;
      end
      ST_MEASURE_MAX: begin
        if (rx_phase_vld_i) begin
          if (rx_max_hit) begin
            stage2_d = 1'b1;
            try_clr  = 1'b1;
            state_d  = ST_RX_RESET;
          end else if (try_spent) begin
            state_d = ST_FAIL;
          end else begin
            state_d = ST_RX_RESET;
          end
        end
      end
      ST_MEASURE_TARGET: begin
        if (rx_phase_vld_i) begin
          if (rx_tgt_hit)     state_d = ST_LOCKED;
          else if (try_spent) state_d = ST_FAIL;
          else                state_d = ST_RX_RESET;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign tmr_clr = (state_d != state_q);
  // count each fresh reset pulse in the current stage
  assign try_inc = (state_d == ST_TX_RESET && state_q != ST_TX_RESET) ||
                   (state_d == ST_RX_RESET && state_q != ST_RX_RESET);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      stage2_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      stage2_q <= stage2_d;
    end
  end

  assign tx_rst_o = (state_q == ST_TX_RESET);
  assign rx_rst_o = (state_q == ST_RX_RESET);
  assign done_o   = (state_q == ST_LOCKED);
  assign err_o    = (state_q == ST_FAIL);
  assign busy_o   = !(state_q inside {ST_IDLE, ST_LOCKED, ST_FAIL});
endmodule

// File: rtl/lat_align_ctrl_chk.sv
module lat_align_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic lol_i,
  input logic tx_phase_vld_i,
  input logic rx_phase_vld_i,
  input logic tx_rst_o,
  input logic rx_rst_o,
  input logic busy_o,
  input logic done_o,
  input logic err_o
);
  // R10
  rst_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_rst_o && rx_rst_o));
  // R10
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({busy_o, done_o, err_o}));
  // R1
  launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> tx_rst_o);
  // R6
  lock_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(rx_phase_vld_i));
  // R7
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(tx_phase_vld_i || rx_phase_vld_i));
  // R3
  rx_kick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_rst_o) |-> $past(tx_phase_vld_i || rx_phase_vld_i));
  // R8
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i && !lol_i) |=> done_o);
  // R7
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> err_o);
endmodule

bind lat_align_ctrl lat_align_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .lol_i         (lol_i),
  .tx_phase_vld_i(tx_phase_vld_i),
  .rx_phase_vld_i(rx_phase_vld_i),
  .tx_rst_o      (tx_rst_o),
  .rx_rst_o      (rx_rst_o),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .err_o         (err_o)
);

// File: tb/lat_align_ctrl_bench.sv
module lat_align_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NPH   = 10;
  localparam int TGT   = 0;
  localparam int TRIES = 12;
  localparam int CW    = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, lol = 1'b0;
  logic [CW-1:0] rst_len = '0, settle_len = '0;
  logic [3:0] tx_code = '0, rx_code = '0;
  logic tx_vld = 1'b0, rx_vld = 1'b0;
  logic tx_rst, rx_rst, busy, done, err;

  always #(CLK_PERIOD/2) clk = ~clk;

  lat_align_ctrl #(
    .PHASE_W(4), .NUM_PHASES(NPH), .TARGET_PHASE(TGT), .CNT_W(CW), .MAX_TRIES(TRIES)
  ) u_lat_align_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .lol_i(lol),
    .rst_len_i(rst_len), .settle_len_i(settle_len),
    .tx_phase_i(tx_code), .tx_phase_vld_i(tx_vld),
    .rx_phase_i(rx_code), .rx_phase_vld_i(rx_vld),
    .tx_rst_o(tx_rst), .rx_rst_o(rx_rst), .busy_o(busy), .done_o(done), .err_o(err)
  );

  int checks = 0, fails = 0;
  int txs[$], rxs[$];
  int tx_ptr = 0, rx_ptr = 0, leff = 1, seff = 1;
  bit glitch = 0;
  int tx_k = -1, rx_k = -1;
  bit tx_prev = 0, rx_prev = 0;
  int tx_pulses = 0, rx_pulses = 0, tx_w = 0, rx_w = 0;
  int width_err = 0, order_err = 0, exp_tx = 0;

  // responder: answers each release at cycle seff, optional decoy at seff-1
  always @(negedge clk) begin
    tx_vld = 1'b0;
    rx_vld = 1'b0;
    if (tx_rst) begin
      if (!tx_prev) begin tx_pulses++; tx_w = 1; end else tx_w++;
      tx_k = -1;
    end else begin
      if (tx_prev) begin
        if (tx_w != leff) width_err++;
        tx_k = 0;
      end else if (tx_k >= 0) tx_k++;
      if (tx_k == seff) begin
        tx_code = 4'(txs[(tx_ptr < txs.size()) ? tx_ptr : txs.size()-1]);
        tx_vld = 1'b1; tx_ptr++;
      end else if (glitch && tx_k == seff-1) begin
        tx_code = 4'(TGT); tx_vld = 1'b1;
      end
    end
    tx_prev = tx_rst;
    if (rx_rst) begin
      if (!rx_prev) begin
        rx_pulses++; rx_w = 1;
        if (tx_pulses != exp_tx) order_err++;
      end else rx_w++;
      rx_k = -1;
    end else begin
      if (rx_prev) begin
        if (rx_w != leff) width_err++;
        rx_k = 0;
      end else if (rx_k >= 0) rx_k++;
      if (rx_k == seff) begin
        rx_code = 4'(rxs[(rx_ptr < rxs.size()) ? rx_ptr : rxs.size()-1]);
        rx_vld = 1'b1; rx_ptr++;
      end else if (glitch && rx_k == seff-1) begin
        rx_code = 4'(NPH-1); rx_vld = 1'b1;
      end
    end
    rx_prev = rx_rst;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // leaves time at e0 + 1
  task automatic launch(int l, int s, bit g, int ntx);
    @(posedge clk); #1;
    rst_len = CW'(l); settle_len = CW'(s);
    leff = (l == 0) ? 1 : l; seff = (s == 0) ? 1 : s; glitch = g;
    tx_ptr = 0; rx_ptr = 0; tx_k = -1; rx_k = -1;
    tx_pulses = 0; rx_pulses = 0; width_err = 0; order_err = 0; exp_tx = ntx;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic run_lock(string tag, int l, int s, bit g, int ntx, int nrx, bit mid);
    int t, n;
    launch(l, s, g, ntx);
    t = leff + seff + 1;
    n = (ntx + nrx) * t;
    if (mid) begin
      repeat (5) @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      repeat (n - 7) @(posedge clk);
    end else repeat (n - 1) @(posedge clk);
    #1;
    chk(tag, "done one edge early", int'(done), 0);
    @(posedge clk); #1;
    chk(tag, "done at due edge", int'(done), 1);
    chk(tag, "busy after lock", int'(busy), 0);
    chk(tag, "err after lock", int'(err), 0);
    chk(tag, "tx pulses", tx_pulses, ntx);
    chk(tag, "rx pulses", rx_pulses, nrx);
    chk({tag, " R2"}, "width errors", width_err, 0);
    chk("R3", "rx reset before tx done", order_err, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "tx_rst in reset", int'(tx_rst), 0);
    chk("R1", "flags in reset", int'({busy, done, err}), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "rx_rst idle", int'(rx_rst), 0);
    chk("R1", "flags idle", int'({busy, done, err}), 0);

    // R3 R5 R6 R9: default lengths, stray start mid-run
    txs = '{3, 0}; rxs = '{2, 9, 5, 0};
    run_lock("R6", 16, 8, 1'b0, 2, 4, 1'b1);
    // R9: mid-run start had no effect, covered by exact timing above
    chk("R9", "locked with start glitch", int'(done), 1);

    // R8: done holds, then lol drops to idle
    repeat (10) @(posedge clk); #1;
    chk("R8", "done held", int'(done), 1);
    lol = 1'b1; @(posedge clk); #1 lol = 1'b0;
    chk("R8", "done after lol", int'(done), 0);
    chk("R8", "busy after lol", int'(busy), 0);

    // R2 R4 R5: sweep lengths, out-of-range codes, decoys during settle
    for (int li = 0; li < 3; li++) begin
      for (int si = 0; si < 3; si++) begin
        int ls[3] = '{0, 1, 3};
        int ss[3] = '{0, 1, 5};
        txs = '{7, 0}; rxs = '{12, 9, 15, 0};
        run_lock("R4 R5", ls[li], ss[si], 1'b1, 2, 4, 1'b0);
      end
    end

    // R9: start from locked restarts
    txs = '{0}; rxs = '{9, 0};
    launch(2, 2, 1'b0, 1);
    chk("R9", "tx_rst after restart", int'(tx_rst), 1);
    chk("R9", "busy after restart", int'(busy), 1);
    repeat (2 * 5 + 5) @(posedge clk); #1;
    chk("R9", "relocked", int'(done), 1);

    // R7: receive stage never hits max
    begin
      int t;
      txs = '{0}; rxs = '{4};
      launch(3, 2, 1'b0, 1);
      t = leff + seff + 1;
      repeat ((1 + TRIES) * t - 1) @(posedge clk); #1;
      chk("R7", "err early", int'(err), 0);
      @(posedge clk); #1;
      chk("R7", "err due", int'(err), 1);
      chk("R7", "busy on err", int'(busy), 0);
      chk("R7", "rx tries", rx_pulses, TRIES);
      repeat (20) @(posedge clk); #1;
      chk("R7", "err held", int'(err), 1);
      chk("R7", "no extra rx", rx_pulses, TRIES);
    end

    // R9: start from fail clears err; then R7 on transmit stage
    begin
      int t;
      txs = '{5}; rxs = '{9, 0};
      launch(1, 1, 1'b0, TRIES);
      chk("R9", "err cleared", int'(err), 0);
      t = leff + seff + 1;
      repeat (TRIES * t - 1) @(posedge clk); #1;
      chk("R7", "tx err early", int'(err), 0);
      @(posedge clk); #1;
      chk("R7", "tx err due", int'(err), 1);
      chk("R7", "tx tries", tx_pulses, TRIES);
      chk("R3", "no rx after tx fail", rx_pulses, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-R act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule